// File: doc/BRIEF.md
# Low-Speed USB Packet Serializer

This block turns a packet into line states on the two USB data wires at the low-speed bit rate. A request starts a packet. The block first sets the idle level (J) on the wires while the drivers are still off. It then turns the drivers on and sends the sync byte, followed by the payload bytes. Every byte goes out least significant bit first. Each bit is NRZI-encoded, and a stuffed bit is inserted after every run of six ones. The packet closes with an end-of-packet sequence, after which the block lets go of the wires. The upstream logic supplies payload bytes one at a time through a valid/ready handshake. The byte count given at the start includes the sync byte, which the block generates itself.

A second request input sends a two-byte handshake packet: sync, then an ACK or NAK packet identifier, with no payload taken from the byte stream. The block also holds the device's active address. A pending address presented on an input becomes active at the end of a data packet. A handshake packet never changes it. CRC generation, packet assembly and the analog drivers are handled elsewhere.

Top module: `ls_usb_tx`

## Requirements
- R1: In reset and while idle, oe, dp, dm, txBusy, done and inReady are all low, and devAddr is 0 after reset.
- R2: In the first clock after an accepted start, the wires carry J (dp=0, dm=1) with oe still low. For the next CLKS_PER_BIT clocks, oe is high with J on the wires, before the first sync bit.
- R3: The first byte sent is sync 0x80, least significant bit first, followed by the payload bytes in order. byteCount counts the sync byte, so a data packet takes exactly byteCount-1 bytes through inValid/inReady, and inReady is only high while oe is high.
- R4: The line states are J (dp=0, dm=1) and K (dp=1, dm=0). A 0 bit toggles the line state and a 1 bit holds it. dp and dm are never both high.
- R5: After six consecutive 1 bits, one extra bit period with a forced toggle is sent. This also applies when the sixth 1 is the last bit of the packet. Any toggle restarts the run count.
- R6: Each line state lasts exactly CLKS_PER_BIT clocks. oe stays high for CLKS_PER_BIT times (sent bits + 4) clocks.
- R7: End of packet is SE0 (dp=dm=0) for two bit times, then J for one bit time. After that oe drops and dp and dm are driven low.
- R8: txBusy is high exactly while oe is high. done is a one-clock pulse in the clock after oe falls.
- R9: startHandshake sends sync then the PID: 0xD2 (ACK) when hsNak=0, 0x5A (NAK) when hsNak=1. inReady stays low throughout.
- R10: devAddr takes newAddr at the edge that raises done, but only after a data packet. It changes at no other time.
- R11: A start request is ignored unless the block is idle. When startData and startHandshake are high together, the handshake is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startData | input | 1 | Request a data packet |
| startHandshake | input | 1 | Request a handshake packet |
| hsNak | input | 1 | Handshake PID select: 0 ACK, 1 NAK |
| byteCount | input | CNT_W | Data packet length including the sync byte |
| inByte | input | 8 | Payload byte |
| inValid | input | 1 | Payload byte present |
| inReady | output | 1 | Payload byte taken on this edge when inValid is high |
| newAddr | input | ADDR_W | Pending device address |
| devAddr | output | ADDR_W | Active device address |
| dp | output | 1 | D+ line level |
| dm | output | 1 | D- line level |
| oe | output | 1 | Line driver enable |
| txBusy | output | 1 | Bus held by the block |
| done | output | 1 | One-clock pulse after bus release |

## Verification
The bench builds the block with CLKS_PER_BIT=4 and CNT_W=4. A four-clock bit keeps each packet to a few hundred clocks. It is still long enough to show that a line state lasts the whole bit and not just one edge. The 4-bit count makes the longest payload small while still covering several cases: a sync-only packet, payloads that force stuffing mid-byte and at the final bit, and both handshake PIDs. It also exercises an address commit after a data packet next to a handshake that must leave the address alone.

// File: rtl/ls_tx_pkg.sv
package ls_tx_pkg;

  localparam logic [7:0] SYNC_BYTE = 8'h80;
  localparam logic [7:0] PID_ACK   = 8'hD2;
  localparam logic [7:0] PID_NAK   = 8'h5A;
  localparam int         RUN_LIMIT = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACQ,
    ST_BITS,
    ST_SE0,
    ST_EOPJ,
    ST_DONE
  } txState_t;

  // Strobes from control to datapath, at most a few set per clock
  typedef struct packed {
    logic prep;     // latch request, set J with drivers off
    logic prepHs;   // request is a handshake
    logic acquire;  // turn drivers on
    logic emit;     // put out the next bit (data or stuffed)
    logic se0;      // drive both lines low
    logic jIdle;    // drive J after SE0
    logic letGo;    // drivers off, lines low
    logic commit;   // copy pending address
  } dpCtrl_t;

endpackage

// File: rtl/ls_tx_ctrl.sv
module ls_tx_ctrl
  import ls_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startData,
  input  logic    startHandshake,
  input  logic    pktEnd,
  output dpCtrl_t strb,
  output logic    txBusy,
  output logic    done
);

  localparam int TICK_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(CLKS_PER_BIT - 1);

  txState_t          state, stateNext;
  logic [TICK_W-1:0] tick;
  logic              eopHalf;
  logic              isHsR;
  logic              timed;
  logic              bitEnd;

  assign timed  = (state == ST_ACQ) || (state == ST_BITS) ||
                  (state == ST_SE0) || (state == ST_EOPJ);
  assign bitEnd = (tick == TICK_LAST);

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (startData || startHandshake) begin
          strb.prep   = 1'b1;
          strb.prepHs = startHandshake;
          stateNext   = ST_PRE;
        end
      end
      ST_PRE: begin
        strb.acquire = 1'b1;
        stateNext    = ST_ACQ;
      end
      ST_ACQ: begin
        if (bitEnd) begin
          strb.emit = 1'b1;
          stateNext = ST_BITS;
        end
      end
      ST_BITS: begin
        if (bitEnd) begin
          if (pktEnd) begin
            strb.se0  = 1'b1;
            stateNext = ST_SE0;
          end else begin
            strb.emit = 1'b1;
          end
        end
      end
      ST_SE0: begin
        if (bitEnd && eopHalf) begin
          strb.jIdle = 1'b1;
          stateNext  = ST_EOPJ;
        end
      end
      ST_EOPJ: begin
        if (bitEnd) begin
          strb.letGo  = 1'b1;
          strb.commit = !isHsR;
          stateNext   = ST_DONE;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tick    <= '0;
      eopHalf <= 1'b0;
      isHsR   <= 1'b0;
    end else begin
      state <= stateNext;
      if (timed && !bitEnd) tick <= tick + 1'b1;
      else                  tick <= '0;
      if (strb.se0)                          eopHalf <= 1'b0;
      else if (state == ST_SE0 && bitEnd)    eopHalf <= 1'b1;
      if (strb.prep) isHsR <= strb.prepHs;
    end
  end

  assign txBusy = timed;
  assign done   = (state == ST_DONE);

endmodule

// File: rtl/ls_tx_datapath.sv
module ls_tx_datapath
  import ls_tx_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           strb,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic              hsNak,
  input  logic [7:0]        inByte,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] newAddr,
  output logic [ADDR_W-1:0] devAddr,
  output logic              pktEnd,
  output logic              dp,
  output logic              dm,
  output logic              oe
);

  localparam logic [2:0] RUN_INIT = 3'(RUN_LIMIT);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic              dpR, dmR, oeR;
  logic              lineK;        // 1 = K, 0 = J
  logic [7:0]        shReg;
  logic [2:0]        bitIdx;
  logic [CNT_W-1:0]  bytesAfter;   // bytes still to load after the current one
  logic [CNT_W-1:0]  fetchLeft;    // payload bytes still to take from upstream
  logic [7:0]        holdByte;
  logic              holdFull;
  logic              dataDone;
  logic [2:0]        onesLeft;
  logic              hsMode;
  logic [7:0]        pidByte;
  logic [ADDR_W-1:0] devAddrR;

  logic              stuffNow;
  logic              bitVal;
  logic              nextK;
  logic [7:0]        nextByte;
  logic [CNT_W-1:0]  payloadCnt;
  logic              takeByte;

  assign stuffNow   = (onesLeft == 3'd0);
  assign bitVal     = shReg[0];
  assign nextK      = lineK ^ (stuffNow | ~bitVal);
  assign nextByte   = hsMode ? pidByte : holdByte;
  assign payloadCnt = (byteCount == '0) ? '0 : (byteCount - CNT_ONE);
  assign inReady    = oeR && !holdFull && (fetchLeft != '0);
  assign takeByte   = inReady && inValid;
  assign pktEnd     = dataDone && !stuffNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dpR        <= 1'b0;
      dmR        <= 1'b0;
      oeR        <= 1'b0;
      lineK      <= 1'b0;
      shReg      <= '0;
      bitIdx     <= '0;
      bytesAfter <= '0;
      fetchLeft  <= '0;
      holdByte   <= '0;
      holdFull   <= 1'b0;
      dataDone   <= 1'b0;
      onesLeft   <= RUN_INIT;
      hsMode     <= 1'b0;
      pidByte    <= '0;
      devAddrR   <= '0;
    end else begin
      if (strb.prep) begin
        dpR      <= 1'b0;
        dmR      <= 1'b1;
        oeR      <= 1'b0;
        lineK    <= 1'b0;
        shReg    <= SYNC_BYTE;
        bitIdx   <= '0;
        onesLeft <= RUN_INIT;
        dataDone <= 1'b0;
        holdFull <= 1'b0;
        hsMode   <= strb.prepHs;
        pidByte  <= hsNak ? PID_NAK : PID_ACK;
        if (strb.prepHs) begin
          bytesAfter <= CNT_ONE;
          fetchLeft  <= '0;
        end else begin
          bytesAfter <= payloadCnt;
          fetchLeft  <= payloadCnt;
        end
      end

      if (strb.acquire) oeR <= 1'b1;

      if (strb.emit) begin
        lineK <= nextK;
        dpR   <= nextK;
        dmR   <= ~nextK;
        if (stuffNow) begin
          onesLeft <= RUN_INIT;
        end else begin
          onesLeft <= bitVal ? (onesLeft - 3'd1) : RUN_INIT;
          bitIdx   <= bitIdx + 3'd1;
          if (bitIdx == 3'd7) begin
            if (bytesAfter != '0) begin
              shReg      <= nextByte;
              bytesAfter <= bytesAfter - CNT_ONE;
              holdFull   <= 1'b0;
            end else begin
              dataDone <= 1'b1;
            end
          end else begin
            shReg <= {1'b0, shReg[7:1]};
          end
        end
      end

      if (strb.se0) begin
        dpR <= 1'b0;
        dmR <= 1'b0;
      end

      if (strb.jIdle) begin
        dpR <= 1'b0;
        dmR <= 1'b1;
      end

      if (strb.letGo) begin
        oeR <= 1'b0;
        dpR <= 1'b0;
        dmR <= 1'b0;
      end

      if (strb.commit) devAddrR <= newAddr;

      // holding buffer is only refilled while empty, so it never meets a load
      if (takeByte) begin
        holdByte  <= inByte;
        holdFull  <= 1'b1;
        fetchLeft <= fetchLeft - CNT_ONE;
      end
    end
  end

  assign dp      = dpR;
  assign dm      = dmR;
  assign oe      = oeR;
  assign devAddr = devAddrR;

endmodule

// File: rtl/ls_usb_tx.sv
module ls_usb_tx
  import ls_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 8,
  parameter int CNT_W        = 8,
  parameter int ADDR_W       = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startData,
  input  logic              startHandshake,
  input  logic              hsNak,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [7:0]        inByte,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] newAddr,
  output logic [ADDR_W-1:0] devAddr,
  output logic              dp,
  output logic              dm,
  output logic              oe,
  output logic              txBusy,
  output logic              done
);

  dpCtrl_t strb;
  logic    pktEnd;

  ls_tx_ctrl #(
    .CLKS_PER_BIT(CLKS_PER_BIT)
  ) ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .startData     (startData),
    .startHandshake(startHandshake),
    .pktEnd        (pktEnd),
    .strb          (strb),
    .txBusy        (txBusy),
    .done          (done)
  );

  ls_tx_datapath #(
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .byteCount(byteCount),
    .hsNak    (hsNak),
    .inByte   (inByte),
    .inValid  (inValid),
    .inReady  (inReady),
    .newAddr  (newAddr),
    .devAddr  (devAddr),
    .pktEnd   (pktEnd),
    .dp       (dp),
    .dm       (dm),
    .oe       (oe)
  );

endmodule

// File: rtl/ls_usb_tx_chk.sv
module ls_usb_tx_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              oe,
  input logic              dp,
  input logic              dm,
  input logic              txBusy,
  input logic              done,
  input logic              inReady,
  input logic [ADDR_W-1:0] devAddr
);

  a_r8_busy_matches_oe: assert property (@(posedge clk) disable iff (!rstN)
    txBusy == oe);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_done_after_release: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(oe) && !oe));

  a_r4_never_both_high: assert property (@(posedge clk) disable iff (!rstN)
    !(dp && dm));

  a_r7_quiet_at_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!dp && !dm));

  a_r3_ready_needs_oe: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> oe);

  a_r10_addr_moves_on_done: assert property (@(posedge clk) disable iff (!rstN)
    (devAddr != $past(devAddr)) |-> done);

endmodule

bind ls_usb_tx ls_usb_tx_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .oe     (oe),
  .dp     (dp),
  .dm     (dm),
  .txBusy (txBusy),
  .done   (done),
  .inReady(inReady),
  .devAddr(devAddr)
);

// File: tb/ls_usb_tx_tb_top.sv
module ls_usb_tx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CPB        = 4;
  localparam int CNT_W      = 4;
  localparam int ADDR_W     = 7;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startData = 1'b0;
  logic              startHandshake = 1'b0;
  logic              hsNak = 1'b0;
  logic [CNT_W-1:0]  byteCount = '0;
  logic [7:0]        inByte = '0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [ADDR_W-1:0] newAddr = '0;
  logic [ADDR_W-1:0] devAddr;
  logic              dp, dm, oe, txBusy, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  ls_usb_tx #(
    .CLKS_PER_BIT(CPB),
    .CNT_W       (CNT_W),
    .ADDR_W      (ADDR_W)
  ) dut_i (
    .clk           (clk),
    .rstN          (rstN),
    .startData     (startData),
    .startHandshake(startHandshake),
    .hsNak         (hsNak),
    .byteCount     (byteCount),
    .inByte        (inByte),
    .inValid       (inValid),
    .inReady       (inReady),
    .newAddr       (newAddr),
    .devAddr       (devAddr),
    .dp            (dp),
    .dm            (dm),
    .oe            (oe),
    .txBusy        (txBusy),
    .done          (done)
  );

  // expected entry: {commit, oe, dp, dm, busy, done}
  logic [5:0]        expQ[$];
  string             tagQ[$];
  byte unsigned      payQ[$];
  string             idleTag = "R1";
  logic [ADDR_W-1:0] expAddr = '0;
  int                nCompared = 0;
  int                nMismatch = 0;
  int                expOe = 0;
  int                oeCnt = 0;
  int                expAcc = 0;
  int                accepted = 0;
  bit                acceptPending = 1'b0;
  bit                hsCur = 1'b0;
  bit                hsReadySeen = 1'b0;
  bit                finished = 1'b0;

  function automatic logic [5:0] lineEntry(bit k);
    return {1'b0, 1'b1, k, !k, 1'b1, 1'b0};
  endfunction

  task automatic pushN(logic [5:0] e, string t, int n);
    for (int i = 0; i < n; i++) begin
      expQ.push_back(e);
      tagQ.push_back(t);
    end
  endtask

  // Behavioural model of the line: NRZI, six-ones stuffing, EOP, release
  task automatic buildPkt(byte unsigned bl[$], bit isData, string bitTag);
    bit lk = 1'b0;
    int ones = 6;
    int nbits = 0;
    pushN({1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, "R2", 1);
    pushN(lineEntry(1'b0), "R2", CPB);
    foreach (bl[j]) begin
      for (int i = 0; i < 8; i++) begin
        if (bl[j][i] == 1'b0) begin
          lk = !lk;
          ones = 6;
        end else begin
          ones--;
        end
        pushN(lineEntry(lk), bitTag, CPB);
        nbits++;
        if (ones == 0) begin
          lk = !lk;
          ones = 6;
          pushN(lineEntry(lk), "R5", CPB);
          nbits++;
        end
      end
    end
    pushN({1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, "R7", 2 * CPB);
    pushN(lineEntry(1'b0), "R7", CPB);
    pushN({isData, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, "R8", 1);
    expOe = CPB * (nbits + 4);
  endtask

  task automatic report(string tag, string what, int act, int exp);
    nMismatch++;
    $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
  endtask

  // Payload source and per-clock comparison, both away from the active edge
  always @(negedge clk) begin
    logic [5:0] e;
    string      t;
    if (!finished) begin
      if (acceptPending) begin
        void'(payQ.pop_front());
        accepted++;
      end
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
      end else begin
        e = 6'b0;
        t = idleTag;
      end
      nCompared++;
      if ({oe, dp, dm, txBusy, done} !== e[4:0])
        report(t, "{oe,dp,dm,busy,done}", int'({oe, dp, dm, txBusy, done}), int'(e[4:0]));
      if (e[5]) expAddr = newAddr;
      nCompared++;
      if (devAddr !== expAddr) report("R10", "devAddr", int'(devAddr), int'(expAddr));
      nCompared++;
      if (!oe && inReady) report("R3", "inReady without oe", 1, 0);
      if (oe) oeCnt++;
      if (e[0]) begin
        nCompared++;
        if (oeCnt != expOe) report("R6", "oe clocks", oeCnt, expOe);
        oeCnt = 0;
        nCompared++;
        if (accepted != expAcc) report("R3", "bytes accepted", accepted, expAcc);
        if (hsCur) begin
          nCompared++;
          if (hsReadySeen) report("R9", "inReady during handshake", 1, 0);
        end
      end
      if (hsCur && inReady) hsReadySeen = 1'b1;
      inValid = (payQ.size() > 0);
      inByte  = (payQ.size() > 0) ? payQ[0] : 8'h00;
      acceptPending = inReady && inValid;
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
  endtask

  // kind: 0 data, 1 handshake, 2 both starts together (R11)
  task automatic runPkt(int kind, bit nak, byte unsigned pay[$], string tag, int pokeAt);
    byte unsigned bl[$];
    @(negedge clk);
    #1;
    bl.push_back(8'h80);
    if (kind == 0) begin
      foreach (pay[j]) bl.push_back(pay[j]);
      payQ = pay;
      expAcc = pay.size();
      hsCur = 1'b0;
    end else begin
      bl.push_back(nak ? 8'h5A : 8'hD2);
      payQ.delete();
      expAcc = 0;
      hsCur = 1'b1;
    end
    accepted = 0;
    hsReadySeen = 1'b0;
    buildPkt(bl, kind == 0, tag);
    hsNak = nak;
    byteCount = CNT_W'(pay.size() + 1);
    startData = (kind != 1);
    startHandshake = (kind != 0);
    @(posedge clk);
    #1;
    startData = 1'b0;
    startHandshake = 1'b0;
    if (pokeAt > 0) begin
      // R11: start requests while busy must be ignored
      repeat (pokeAt) @(posedge clk);
      #1;
      startHandshake = 1'b1;
      startData = 1'b1;
      @(posedge clk);
      #1;
      startHandshake = 1'b0;
      startData = 1'b0;
    end
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nMismatch++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state compared on every clock while reset is held
    repeat (3) @(negedge clk);
    #1;
    rstN = 1'b1;
    newAddr = 7'h15;
    repeat (2) @(negedge clk);

    runPkt(0, 1'b0, '{8'hC3, 8'h5A}, "R4", 0);           // R3 R4 R10: commit 0x15
    runPkt(0, 1'b0, '{8'hFF, 8'hFC}, "R4", 0);           // R5 mid-byte and at last bit
    runPkt(0, 1'b0, '{}, "R3", 0);                       // sync only
    newAddr = 7'h2A;
    runPkt(1, 1'b0, '{}, "R9", 0);                       // R9 ACK, R10 no commit
    runPkt(1, 1'b1, '{}, "R9", 0);                       // R9 NAK
    idleTag = "R11";
    runPkt(0, 1'b0, '{8'h01, 8'h7E, 8'hFF, 8'h00}, "R11", 20);  // R11 ignored start
    runPkt(2, 1'b1, '{}, "R11", 0);                      // R11 handshake wins
    newAddr = 7'h33;
    runPkt(0, 1'b0, '{8'h3F, 8'h80, 8'hAA}, "R4", 0);    // R10 commit 0x33
    idleTag = "R1";
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end

endmodule